// File: doc/BRIEF.md
# Byte-Wide Stack Processor Core

This block is a small multi-cycle processor working on 8-bit words. It holds eight 8-bit registers, one 3-bit comparison flag register and a single 256-byte memory that stores program, data and stack together. Every instruction is one opcode byte followed by two operand bytes. The core always fetches all three bytes, then executes the instruction in a fourth cycle.

The instruction set covers these groups:
- immediate loads
- 8-bit add and multiply
- unsigned compare
- stack push and pop
- subroutine call and return
- jumps through a register, either unconditional or on the equal flag
- printing a register
- halt

Register 7 is the stack pointer, and the stack grows downward from 0xF4.

In use, the surrounding logic holds reset and writes the program image through the load port. It then releases reset, and the core begins fetching at address 0. Printed values appear on a one-cycle strobe with a data byte. When the core stops, `halted` rises and stays high until the next reset.

Top module: `byte_stack_core`

## Requirements
- R1: While `rst` is high, `halted` and `print_valid` are low. After reset the PC is 0, register 7 holds 0xF4, all other registers hold 0 and the flags hold 3'b001.
- R2: While `rst` is high, each cycle with `load_we` high writes `load_data` into memory at `load_addr`. Memory contents are kept across reset.
- R3: Each instruction takes exactly four clock cycles. When opcode bit 4 is 0, the PC afterwards equals the PC plus opcode[7:6] plus 1, modulo 256. A register operand selects the register given by the low 3 bits of its byte.
- R4: LDI (0x82, reg, imm) writes the immediate. ADD (0xA0) and MUL (0xA2) write the low 8 bits of regA+regB or regA*regB into regA. None of them changes the flags.
- R5: CMP (0xA7, regA, regB) sets the flags to exactly one of 3'b100 (A<B), 3'b010 (A>B) or 3'b001 (equal), comparing as unsigned numbers. Only CMP changes the flags.
- R6: PUSH (0x45, reg) decrements register 7 and then stores the register at that address. POP (0x46, reg) loads memory at register 7 into the register and then increments register 7. Stack arithmetic wraps modulo 256.
- R7: CALL (0x50, reg) decrements register 7, stores the CALL address plus 2 there, and jumps to the register's value. RET (0x11) loads the PC from memory at register 7 and then increments register 7.
- R8: JMP (0x54, reg) jumps to the register's value. JEQ (0x55) jumps when flag bit 0 is set and JNE (0x56) jumps when it is clear. A conditional jump that is not taken adds 2 to the PC.
- R9: PRN (0x47, reg) raises `print_valid` for exactly one cycle, in the cycle after its execute cycle, with the register's value on `print_data`.
- R10: HLT (0x01) and every opcode not listed here set `halted` four cycles after their fetch begins. From then until reset, `halted` stays high, with no memory writes and no prints.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset; the load port works only while it is high |
| load_we | input | 1 | Write strobe of the program-load port |
| load_addr | input | 8 | Memory address of the load write |
| load_data | input | 8 | Byte written by the load port |
| print_valid | output | 1 | One-cycle pulse produced by PRN |
| print_data | output | 8 | Register value printed by PRN |
| halted | output | 1 | High once the core has stopped |

## Verification
The checker properties are disabled during reset. They assume that the program image is complete before reset falls and that the load port stays idle while the core runs. The stimulus loads all 256 bytes under reset and never drives `load_we` afterwards. The bench's reference model follows the opcode rules above. It does not cover pushing register 7 or popping into it, where the two register-7 updates collide, so generated programs draw stack and destination registers only from 0 to 6. Programs that are not taken from a stack-free pattern end in HLT, and the directed programs place jump targets in zero-filled memory above the code.

// File: rtl/bsc_pkg.sv
package bsc_pkg;

   typedef enum logic [2:0] {
      PH_FETCH,
      PH_OPA,
      PH_OPB,
      PH_EXEC,
      PH_HALT
   } phase_e;

   localparam logic [7:0] OP_LDI  = 8'h82;
   localparam logic [7:0] OP_PRN  = 8'h47;
   localparam logic [7:0] OP_ADD  = 8'hA0;
   localparam logic [7:0] OP_MUL  = 8'hA2;
   localparam logic [7:0] OP_CMP  = 8'hA7;
   localparam logic [7:0] OP_PUSH = 8'h45;
   localparam logic [7:0] OP_POP  = 8'h46;
   localparam logic [7:0] OP_CALL = 8'h50;
   localparam logic [7:0] OP_RET  = 8'h11;
   localparam logic [7:0] OP_JMP  = 8'h54;
   localparam logic [7:0] OP_JEQ  = 8'h55;
   localparam logic [7:0] OP_JNE  = 8'h56;
   localparam logic [7:0] OP_HLT  = 8'h01;

   localparam logic [2:0] FLG_LT = 3'b100;
   localparam logic [2:0] FLG_GT = 3'b010;
   localparam logic [2:0] FLG_EQ = 3'b001;

endpackage

// File: rtl/bsc_mem.sv
module bsc_mem #(
   parameter int ADDR_W = 8,
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              we,
   input  logic [ADDR_W-1:0] waddr,
   input  logic [DATA_W-1:0] wdata,
   input  logic [ADDR_W-1:0] raddr,
   output logic [DATA_W-1:0] rdata
);
   localparam int DEPTH = 1 << ADDR_W;

   logic [DATA_W-1:0] store [DEPTH];

   always_ff @(posedge clk) begin
      if (we) store[waddr] <= wdata;
   end

   assign rdata = store[raddr];
endmodule

// File: rtl/bsc_regs.sv
module bsc_regs #(
   parameter int              DATA_W   = 8,
   parameter int              NUM_REGS = 8,
   parameter logic [DATA_W-1:0] SP_INIT = 8'hF4,
   localparam int             IDX_W    = $clog2(NUM_REGS)
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              w_en,
   input  logic [IDX_W-1:0]  w_idx,
   input  logic [DATA_W-1:0] w_data,
   input  logic              sp_en,
   input  logic [DATA_W-1:0] sp_data,
   input  logic [IDX_W-1:0]  a_idx,
   input  logic [IDX_W-1:0]  b_idx,
   output logic [DATA_W-1:0] a_data,
   output logic [DATA_W-1:0] b_data,
   output logic [DATA_W-1:0] sp_q
);
   localparam int SP_IDX = NUM_REGS - 1;

   logic [NUM_REGS-1:0][DATA_W-1:0] bank;

   for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
      logic [DATA_W-1:0] r_q;
      if (i == SP_IDX) begin : g_sp
         always_ff @(posedge clk) begin
            if (rst)                                 r_q <= SP_INIT;
            else if (w_en && w_idx == IDX_W'(i))     r_q <= w_data;
            else if (sp_en)                          r_q <= sp_data;
         end
      end else begin : g_gp
         always_ff @(posedge clk) begin
            if (rst)                                 r_q <= '0;
            else if (w_en && w_idx == IDX_W'(i))     r_q <= w_data;
         end
      end
      assign bank[i] = r_q;
   end

   assign a_data = bank[a_idx];
   assign b_data = bank[b_idx];
   assign sp_q   = bank[SP_IDX];
endmodule

// File: rtl/bsc_alu.sv
module bsc_alu #(
   parameter int DATA_W   = 8,
   parameter bit FAST_MUL = 1'b1
) (
   input  logic [DATA_W-1:0] a,
   input  logic [DATA_W-1:0] b,
   output logic [DATA_W-1:0] sum,
   output logic [DATA_W-1:0] prod,
   output logic [2:0]        cmp_flags
);
   import bsc_pkg::*;

   assign sum = a + b;

   if (FAST_MUL) begin : g_mul_native
      assign prod = a * b;
   end else begin : g_mul_shift
      always_comb begin
         prod = '0;
         for (int k = 0; k < DATA_W; k++) begin
            if (b[k]) prod = prod + (a << k);
         end
      end
   end

   always_comb begin
      if (a < b)      cmp_flags = FLG_LT;
      else if (a > b) cmp_flags = FLG_GT;
      else            cmp_flags = FLG_EQ;
   end
endmodule

// File: rtl/byte_stack_core.sv
module byte_stack_core #(
   parameter int              DATA_W   = 8,
   parameter int              NUM_REGS = 8,
   parameter logic [DATA_W-1:0] SP_INIT = 8'hF4,
   parameter bit              FAST_MUL = 1'b1
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              load_we,
   input  logic [DATA_W-1:0] load_addr,
   input  logic [DATA_W-1:0] load_data,
   output logic              print_valid,
   output logic [DATA_W-1:0] print_data,
   output logic              halted
);
   import bsc_pkg::*;

   localparam int IDX_W = $clog2(NUM_REGS);

   if (DATA_W != 8) begin : g_bad_width
      $error("byte_stack_core: opcode decode needs DATA_W == 8");
   end
   if (NUM_REGS != (1 << IDX_W) || NUM_REGS < 2) begin : g_bad_regs
      $error("byte_stack_core: NUM_REGS must be a power of two >= 2");
   end

   phase_e            phase;
   logic [DATA_W-1:0] pc, ir, opa, opb;
   logic [2:0]        flags;
   logic              in_exec;

   logic [DATA_W-1:0] rd_addr, rd_data;
   logic              mem_we;
   logic [DATA_W-1:0] mem_waddr, mem_wdata;

   logic [DATA_W-1:0] ra_data, rb_data, sp_q;
   logic [DATA_W-1:0] alu_sum, alu_prod;
   logic [2:0]        alu_cmp;

   logic              rf_we, sp_we, core_we, go_halt, do_print;
   logic [DATA_W-1:0] rf_wdata, sp_next, core_waddr, core_wdata, pc_next;
   logic [2:0]        flags_next;
   logic              rf_we_g, sp_we_g, core_we_g;

   assign in_exec = (phase == PH_EXEC);
   assign halted  = (phase == PH_HALT);

   always_comb begin
      case (phase)
         PH_OPA:  rd_addr = pc + DATA_W'(1);
         PH_OPB:  rd_addr = pc + DATA_W'(2);
         PH_EXEC: rd_addr = sp_q;
         default: rd_addr = pc;
      endcase
   end

   assign rf_we_g   = rf_we & in_exec;
   assign sp_we_g   = sp_we & in_exec;
   assign core_we_g = core_we & in_exec;

   assign mem_we    = rst ? load_we   : core_we_g;
   assign mem_waddr = rst ? load_addr : core_waddr;
   assign mem_wdata = rst ? load_data : core_wdata;

   bsc_mem #(.ADDR_W(DATA_W), .DATA_W(DATA_W)) u_mem (
      .clk   (clk),
      .we    (mem_we),
      .waddr (mem_waddr),
      .wdata (mem_wdata),
      .raddr (rd_addr),
      .rdata (rd_data)
   );

   bsc_regs #(.DATA_W(DATA_W), .NUM_REGS(NUM_REGS), .SP_INIT(SP_INIT)) u_regs (
      .clk     (clk),
      .rst     (rst),
      .w_en    (rf_we_g),
      .w_idx   (opa[IDX_W-1:0]),
      .w_data  (rf_wdata),
      .sp_en   (sp_we_g),
      .sp_data (sp_next),
      .a_idx   (opa[IDX_W-1:0]),
      .b_idx   (opb[IDX_W-1:0]),
      .a_data  (ra_data),
      .b_data  (rb_data),
      .sp_q    (sp_q)
   );

   bsc_alu #(.DATA_W(DATA_W), .FAST_MUL(FAST_MUL)) u_alu (
      .a         (ra_data),
      .b         (rb_data),
      .sum       (alu_sum),
      .prod      (alu_prod),
      .cmp_flags (alu_cmp)
   );

   // Execute-phase decode: every effect is gated by in_exec above.
   always_comb begin
      rf_we      = 1'b0;
      rf_wdata   = '0;
      sp_we      = 1'b0;
      sp_next    = sp_q;
      core_we    = 1'b0;
      core_waddr = sp_q - DATA_W'(1);
      core_wdata = ra_data;
      pc_next    = pc + DATA_W'(ir[7:6]) + DATA_W'(1);
      flags_next = flags;
      go_halt    = 1'b0;
      do_print   = 1'b0;
      case (ir)
         OP_LDI:  begin rf_we = 1'b1; rf_wdata = opb; end
         OP_PRN:  do_print = 1'b1;
         OP_ADD:  begin rf_we = 1'b1; rf_wdata = alu_sum; end
         OP_MUL:  begin rf_we = 1'b1; rf_wdata = alu_prod; end
         OP_CMP:  flags_next = alu_cmp;
         OP_PUSH: begin
            sp_we   = 1'b1;
            sp_next = sp_q - DATA_W'(1);
            core_we = 1'b1;
         end
         OP_POP: begin
            rf_we    = 1'b1;
            rf_wdata = rd_data;
            sp_we    = 1'b1;
            sp_next  = sp_q + DATA_W'(1);
         end
         OP_CALL: begin
            sp_we      = 1'b1;
            sp_next    = sp_q - DATA_W'(1);
            core_we    = 1'b1;
            core_wdata = pc + DATA_W'(2);
            pc_next    = ra_data;
         end
         OP_RET: begin
            pc_next = rd_data;
            sp_we   = 1'b1;
            sp_next = sp_q + DATA_W'(1);
         end
         OP_JMP:  pc_next = ra_data;
         OP_JEQ:  pc_next = flags[0] ? ra_data : pc + DATA_W'(2);
         OP_JNE:  pc_next = flags[0] ? pc + DATA_W'(2) : ra_data;
         default: go_halt = 1'b1;
      endcase
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         phase       <= PH_FETCH;
         pc          <= '0;
         ir          <= '0;
         opa         <= '0;
         opb         <= '0;
         flags       <= FLG_EQ;
         print_valid <= 1'b0;
         print_data  <= '0;
      end else begin
         print_valid <= 1'b0;
         case (phase)
            PH_FETCH: begin ir  <= rd_data; phase <= PH_OPA;  end
            PH_OPA:   begin opa <= rd_data; phase <= PH_OPB;  end
            PH_OPB:   begin opb <= rd_data; phase <= PH_EXEC; end
            PH_EXEC: begin
               if (go_halt) begin
                  phase <= PH_HALT;
               end else begin
                  pc    <= pc_next;
                  flags <= flags_next;
                  phase <= PH_FETCH;
                  if (do_print) begin
                     print_valid <= 1'b1;
                     print_data  <= ra_data;
                  end
               end
            end
            default: phase <= PH_HALT;
         endcase
      end
   end
endmodule

// File: rtl/bsc_checker.sv
module bsc_checker #(
   parameter int DATA_W = 8
) (
   input logic              clk,
   input logic              rst,
   input logic              halted,
   input logic              print_valid,
   input logic [2:0]        flags,
   input logic [DATA_W-1:0] pc,
   input logic              in_exec,
   input logic              core_we
);
   // R10: once stopped, the core stays stopped
   a_r10_halt_sticky: assert property (@(posedge clk) disable iff (rst)
      halted |=> halted);

   // R10: no memory write while stopped
   a_r10_no_write_halted: assert property (@(posedge clk) disable iff (rst)
      halted |-> !core_we);

   // R10: no print while stopped
   a_r10_no_print_halted: assert property (@(posedge clk) disable iff (rst)
      halted |-> !print_valid);

   // R9: print strobe lasts one cycle
   a_r9_print_one_cycle: assert property (@(posedge clk) disable iff (rst)
      print_valid |=> !print_valid);

   // R5: flags always one-hot
   a_r5_flags_onehot: assert property (@(posedge clk) disable iff (rst)
      $countones(flags) == 1);

   // R5: flags change only at an execute edge
   a_r5_flags_steady: assert property (@(posedge clk) disable iff (rst)
      !in_exec |=> $stable(flags));

   // R3: PC changes only at an execute edge
   a_r3_pc_steady: assert property (@(posedge clk) disable iff (rst)
      !in_exec |=> $stable(pc));
endmodule

bind byte_stack_core bsc_checker #(.DATA_W(DATA_W)) u_chk (
   .clk         (clk),
   .rst         (rst),
   .halted      (halted),
   .print_valid (print_valid),
   .flags       (flags),
   .pc          (pc),
   .in_exec     (in_exec),
   .core_we     (core_we_g)
);

// File: tb/byte_stack_core_tb.sv
module byte_stack_core_tb;
   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic       load_we = 1'b0;
   logic [7:0] load_addr = 8'h00;
   logic [7:0] load_data = 8'h00;
   logic       print_valid;
   logic [7:0] print_data;
   logic       halted;

   always #10 clk = ~clk;

   byte_stack_core u_dut (
      .clk         (clk),
      .rst         (rst),
      .load_we     (load_we),
      .load_addr   (load_addr),
      .load_data   (load_data),
      .print_valid (print_valid),
      .print_data  (print_data),
      .halted      (halted)
   );

   int n_tests = 0;
   int n_fail  = 0;
   int wd_cnt  = 0;

   logic [7:0] prog  [256];
   logic [7:0] m_mem [256];
   logic [7:0] m_reg [8];
   logic [7:0] m_pc;
   logic [2:0] m_flags;
   logic [7:0] exp_pr [512];
   int         n_exp;
   int         m_steps;
   int         plen;

   always @(posedge clk) begin
      wd_cnt++;
      if (wd_cnt > 190000) begin
         n_fail++;
         $display("FAIL watchdog: actual %0d cycles expected < 190000", wd_cnt);
         $display("[TB] %0d tests run, %0d failed", n_tests + 1, n_fail);
         $finish;
      end
   end

   task automatic chk(input bit ok, input string req, input string what,
                      input int act, input int exp);
      n_tests++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   task automatic clear_prog();
      for (int i = 0; i < 256; i++) prog[i] = 8'h00;
      plen = 0;
   endtask

   task automatic e1(input logic [7:0] b0);
      prog[plen % 256] = b0;
      plen++;
   endtask

   task automatic e2(input logic [7:0] b0, input logic [7:0] b1);
      e1(b0); e1(b1);
   endtask

   task automatic e3(input logic [7:0] b0, input logic [7:0] b1, input logic [7:0] b2);
      e1(b0); e1(b1); e1(b2);
   endtask

   // Reference model of the instruction rules
   task automatic model_run();
      for (int i = 0; i < 256; i++) m_mem[i] = prog[i];
      for (int i = 0; i < 8; i++) m_reg[i] = 8'h00;
      m_reg[7] = 8'hF4;
      m_pc     = 8'h00;
      m_flags  = 3'b001;
      n_exp    = 0;
      m_steps  = 0;
      for (int s = 0; s < 4000; s++) begin
         logic [7:0] op, a, b, ra, rb;
         logic       stop;
         op = m_mem[m_pc];
         a  = m_mem[m_pc + 8'd1];
         b  = m_mem[m_pc + 8'd2];
         ra = m_reg[a[2:0]];
         rb = m_reg[b[2:0]];
         stop = 1'b0;
         m_steps++;
         case (op)
            8'h82: m_reg[a[2:0]] = b;
            8'h47: begin
               if (n_exp < 512) exp_pr[n_exp] = ra;
               n_exp++;
            end
            8'hA0: m_reg[a[2:0]] = ra + rb;
            8'hA2: m_reg[a[2:0]] = 8'(ra * rb);
            8'hA7: m_flags = (ra < rb) ? 3'b100 : (ra > rb) ? 3'b010 : 3'b001;
            8'h45: begin
               m_reg[7] = m_reg[7] - 8'd1;
               m_mem[m_reg[7]] = ra;
            end
            8'h46: begin
               m_reg[a[2:0]] = m_mem[m_reg[7]];
               m_reg[7] = m_reg[7] + 8'd1;
            end
            8'h50: begin
               m_reg[7] = m_reg[7] - 8'd1;
               m_mem[m_reg[7]] = m_pc + 8'd2;
               m_pc = ra;
            end
            8'h11: begin
               m_pc = m_mem[m_reg[7]];
               m_reg[7] = m_reg[7] + 8'd1;
            end
            8'h54: m_pc = ra;
            8'h55: m_pc = m_flags[0] ? ra : m_pc + 8'd2;
            8'h56: m_pc = m_flags[0] ? m_pc + 8'd2 : ra;
            default: stop = 1'b1;
         endcase
         if (stop) break;
         if (!op[4]) m_pc = m_pc + {6'b0, op[7:6]} + 8'd1;
      end
   endtask

   task automatic run_prog(input string name);
      int cycles;
      int got;
      model_run();
      rst = 1'b1;
      @(negedge clk);
      for (int i = 0; i < 256; i++) begin
         load_we   = 1'b1;
         load_addr = 8'(i);
         load_data = prog[i];
         @(negedge clk);
      end
      load_we = 1'b0;
      @(negedge clk);
      chk(halted === 1'b0, "R1", {name, " halted under reset"}, int'(halted), 0);
      chk(print_valid === 1'b0, "R1", {name, " print_valid under reset"}, int'(print_valid), 0);
      rst    = 1'b0;
      cycles = 0;
      got    = 0;
      while (1) begin
         @(negedge clk);
         cycles++;
         if (print_valid === 1'b1) begin
            if (got < n_exp && got < 512)
               chk(print_data === exp_pr[got], "R9", {name, " print value"},
                   int'(print_data), int'(exp_pr[got]));
            got++;
         end
         if (halted === 1'b1 || cycles > 20000) break;
      end
      chk(got == n_exp, "R9", {name, " print count"}, got, n_exp);
      chk(cycles == 4 * m_steps, "R3", {name, " cycles to halt"}, cycles, 4 * m_steps);
      for (int k = 0; k < 10; k++) begin
         @(negedge clk);
         if (halted !== 1'b1 || print_valid !== 1'b0) begin
            chk(1'b0, "R10", {name, " stays halted and silent"},
                int'({halted, print_valid}), 2);
            break;
         end
      end
      chk(halted === 1'b1, "R10", {name, " halted after idle"}, int'(halted), 1);
      rst = 1'b1;
   endtask

   function automatic logic [7:0] rnd_reg6();
      return 8'($urandom_range(0, 6));
   endfunction

   initial begin
      void'($urandom(32'd20240611));

      // R1 R4 R9 R3: SP reset value, LDI, ADD and MUL wrap, index low bits
      clear_prog();
      e2(8'h47, 8'h07);
      e3(8'h82, 8'h00, 8'd200);
      e3(8'h82, 8'h01, 8'd100);
      e3(8'hA0, 8'h00, 8'h01);
      e2(8'h47, 8'h00);
      e3(8'h82, 8'h02, 8'd20);
      e3(8'h82, 8'h03, 8'd13);
      e3(8'hA2, 8'h02, 8'h03);
      e2(8'h47, 8'h02);
      e3(8'h82, 8'h0A, 8'h33);
      e2(8'h47, 8'h02);
      e1(8'h01);
      run_prog("R4 arith");

      // R5 R8: compare, flags untouched by ADD, conditional jumps
      clear_prog();
      e3(8'h82, 8'h00, 8'h80);
      e3(8'h82, 8'h01, 8'h01);
      e3(8'h82, 8'h06, 8'h40);
      e3(8'hA7, 8'h00, 8'h01);
      e2(8'h55, 8'h06);
      e2(8'h47, 8'h00);
      e2(8'h56, 8'h06);
      e2(8'h47, 8'h01);
      e1(8'h01);
      plen = 8'h40;
      e3(8'h82, 8'h01, 8'h80);
      e3(8'h82, 8'h06, 8'h60);
      e3(8'hA7, 8'h00, 8'h01);
      e3(8'hA0, 8'h02, 8'h03);
      e2(8'h56, 8'h06);
      e2(8'h47, 8'h01);
      e2(8'h55, 8'h06);
      e2(8'h47, 8'h00);
      e1(8'h01);
      plen = 8'h60;
      e2(8'h47, 8'h06);
      e1(8'h01);
      run_prog("R5 R8 branch");

      // R6 R7: push/pop ordering and call/return
      clear_prog();
      e3(8'h82, 8'h05, 8'h40);
      e3(8'h82, 8'h01, 8'h11);
      e2(8'h45, 8'h01);
      e3(8'h82, 8'h01, 8'h00);
      e2(8'h46, 8'h02);
      e2(8'h47, 8'h02);
      e2(8'h50, 8'h05);
      e2(8'h47, 8'h07);
      e1(8'h01);
      plen = 8'h40;
      e2(8'h47, 8'h07);
      e1(8'h11);
      run_prog("R6 R7 stack");

      // R6: stack wrap through address 0xFF
      clear_prog();
      e3(8'h82, 8'h07, 8'h00);
      e3(8'h82, 8'h01, 8'h5A);
      e2(8'h45, 8'h01);
      e2(8'h47, 8'h07);
      e2(8'h46, 8'h03);
      e2(8'h47, 8'h03);
      e2(8'h47, 8'h07);
      e1(8'h01);
      run_prog("R6 wrap");

      // R8: unconditional jump skips code
      clear_prog();
      e3(8'h82, 8'h06, 8'h30);
      e2(8'h54, 8'h06);
      e2(8'h47, 8'h06);
      e1(8'h01);
      plen = 8'h30;
      e3(8'h82, 8'h06, 8'hC3);
      e2(8'h47, 8'h06);
      e1(8'h01);
      run_prog("R8 jmp");

      // R10: unknown opcode halts like HLT
      clear_prog();
      e3(8'h82, 8'h00, 8'h07);
      e2(8'h47, 8'h00);
      e1(8'hFF);
      e2(8'h47, 8'h00);
      e1(8'h01);
      run_prog("R10 unknown op");

      // R2 R3 R4 R5 R6: random straight-line programs
      for (int p = 0; p < 10; p++) begin
         clear_prog();
         for (int n = 0; n < 25; n++) begin
            case ($urandom_range(0, 6))
               0: e3(8'h82, rnd_reg6(), 8'($urandom_range(0, 255)));
               1: e3(8'hA0, rnd_reg6(), 8'($urandom_range(0, 7)));
               2: e3(8'hA2, rnd_reg6(), 8'($urandom_range(0, 7)));
               3: e3(8'hA7, 8'($urandom_range(0, 7)), 8'($urandom_range(0, 7)));
               4: e2(8'h45, rnd_reg6());
               5: e2(8'h46, rnd_reg6());
               default: e2(8'h47, 8'($urandom_range(0, 255)));
            endcase
         end
         e1(8'h01);
         run_prog("R2 random");
      end

      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end
endmodule